// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-port synchronous static RAM intended as the data store of a cache. Address, write data and the clocked strobes are captured on the rising clock edge. Reads are pipelined: the array is read from a registered address, and the word is held in an output register that the caller sees one edge later. A burst of four words begins with either of two start strobes. The first, `cpu_start`, is the processor strobe. It always makes a read. The second, `ctl_start`, is the cache-controller strobe. It makes a write when write enables are active, and a read otherwise. After a burst begins, an internal two-bit counter produces the following addresses. The counter steps only on cycles where `burst_step` is high.

Writes take effect in the array on the same edge that registers them, with no separate write pulse. They can target single 9-bit byte lanes, or the whole word through a global write. A start strobe with the chip select low is a deselect. It ends the burst, and the output driver switches off two clocks later. The output enable and the sleep input are combinational and have no clock.

The data interfaces have no back-pressure. A new cycle is accepted on every clock edge while `sleep` is low, so there is no ready signal. The read side shows, through `rdata_drive`, when `rdata` would be driving the shared bus.

Top module: `sram_burst_pipe`

## Requirements
- R1: A read started at clock edge E0 puts the addressed word on `rdata` after edge E0+1, and `rdata_drive` goes high then, not after E0.
- R2: When `cpu_start` is high, the cycle is a read and nothing is written, even if `ctl_start`, `wr_all` or `wr_en` are also high.
- R3: A `ctl_start` cycle with `chip_sel` high and write enables active writes `wdata` at `addr` on that same edge.
- R4: When `interleave` is 0, beat k of a burst (k = 0..3) accesses the start address with the two low bits replaced by (start low bits + k) mod 4. The upper bits stay fixed.
- R5: When `interleave` is 1, beat k accesses the start address with the two low bits replaced by (start low bits XOR k).
- R6: During an active burst with no start strobe, the counter advances only when `burst_step` is high. Otherwise the cycle accesses the same address again, as a write if write enables are active and as a read if not.
- R7: Lane i covers `wdata` bits [9i+8:9i]. Lane i is written only when `lane_en[i]` and `wr_en` are both high. If `wr_en` is low, `lane_en` has no effect.
- R8: When `wr_all` is high, every lane is written, whatever the values of `wr_en` and `lane_en`.
- R9: A start strobe with `chip_sel` low, registered at edge E0, ends the burst. `rdata_drive` stays high after E0 and after E0+1, and goes low after E0+2, provided no read arrives in between.
- R10: `out_en` low forces `rdata_drive` low at once, with no clock edge, and leaves `rdata` unchanged.
- R11: While `sleep` is high, `rdata_drive` is low, no cycle is accepted, nothing is written, and both the array contents and `rdata` are kept.
- R12: After reset, `rdata` is 0 and `rdata_drive` is 0.
- R13: When no burst is active, a cycle without a start strobe accesses nothing. `burst_step` and the write enables are ignored on such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address, captured by a start strobe |
| cpu_start | input | 1 | Processor burst start; always a read |
| ctl_start | input | 1 | Controller burst start; a write if write enables are active |
| chip_sel | input | 1 | Select; low with a start strobe means deselect |
| burst_step | input | 1 | Advance the internal burst counter |
| interleave | input | 1 | Burst order select, not clocked: 0 linear, 1 interleaved |
| wr_en | input | 1 | Write enable that qualifies `lane_en` |
| lane_en | input | LANES | Per-lane write enables |
| wr_all | input | 1 | Global write of all lanes |
| wdata | input | LANES*LANE_W | Write data |
| out_en | input | 1 | Output enable, not clocked |
| sleep | input | 1 | Sleep, not clocked; freezes the block |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_drive | output | 1 | High when `rdata` would drive the bus |

## Verification
Some properties are checked by assertions on every cycle. These are the combinational gating of `rdata_drive` by `out_en` and `sleep`, the freeze of `rdata` while asleep, the absence of any write mask while the processor strobe is high, and the two-edge latency from an accepted processor read to the output driver turning on. Other behaviour can only be shown by the bench's directed scenarios, because it depends on what the array holds afterwards. This covers linear and interleaved beat order, a hold cycle rewriting the same word, partial lane writes, global writes, writes ignored when no burst is active, and the timing of the two-cycle deselect.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // Low two address bits of a beat, from the starting low bits and beat count.
  function automatic logic [1:0] beat_offset(input logic [1:0] first,
                                             input logic [1:0] cnt,
                                             input logic       interleave);
    return interleave ? (first ^ cnt) : (first + cnt);
  endfunction

endpackage

// File: rtl/sram_write_qual.sv
module sram_write_qual #(
  parameter int LANES = 4
) (
  input  logic             wr_en,
  input  logic             wr_all,
  input  logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] lane_mask,
  output logic             wr_any
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mask[i] = wr_all | (wr_en & lane_en[i]);
  end

  assign wr_any = |lane_mask;

endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              cpu_start,
  input  logic              ctl_start,
  input  logic              chip_sel,
  input  logic              burst_step,
  input  logic              interleave,
  input  logic              wr_any,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              acc_op,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              desel
);

  logic              active_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_n;
  logic              start_ok;

  always_comb begin
    acc_op   = ACC_NONE;
    acc_addr = base_q;
    cnt_n    = cnt_q;
    desel    = 1'b0;
    start_ok = 1'b0;
    if (!sleep) begin
      if (cpu_start || ctl_start) begin
        if (!chip_sel) begin
          desel = 1'b1;
        end else begin
          start_ok = 1'b1;
          acc_addr = addr;
          acc_op   = (cpu_start || !wr_any) ? ACC_READ : ACC_WRITE;
        end
      end else if (active_q) begin
        cnt_n    = burst_step ? cnt_q + 2'd1 : cnt_q;
        acc_addr = {base_q[ADDR_W-1:2], beat_offset(base_q[1:0], cnt_n, interleave)};
        acc_op   = wr_any ? ACC_WRITE : ACC_READ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (!sleep) begin
      if (start_ok) begin
        active_q <= 1'b1;
        base_q   <= addr;
        cnt_q    <= '0;
      end else if (desel) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        cnt_q <= cnt_n;
      end
    end
  end

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we_mask,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rword
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (we_mask[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
    end
  end

  assign rword = mem[raddr];

endmodule

// File: rtl/sram_read_pipe.sv
module sram_read_pipe #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              desel,
  input  logic [DATA_W-1:0] rword,
  output logic [ADDR_W-1:0] raddr_q,
  output logic [DATA_W-1:0] dout_q,
  output logic              drv_q
);

  logic rd_pend_q;
  logic ds1_q;
  logic ds2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      raddr_q   <= '0;
      ds1_q     <= 1'b0;
      ds2_q     <= 1'b0;
      dout_q    <= '0;
      drv_q     <= 1'b0;
    end else if (!sleep) begin
      rd_pend_q <= rd_go;
      if (rd_go) raddr_q <= rd_addr;
      ds1_q <= desel;
      ds2_q <= ds1_q;
      if (rd_pend_q) begin
        dout_q <= rword;
        drv_q  <= 1'b1;
      end else if (ds2_q) begin
        drv_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sram_burst_pipe.sv
module sram_burst_pipe
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cpu_start,
  input  logic                    ctl_start,
  input  logic                    chip_sel,
  input  logic                    burst_step,
  input  logic                    interleave,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        lane_en,
  input  logic                    wr_all,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    out_en,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drive
);

  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0]  lane_mask;
  logic              wr_any;
  acc_e              acc_op;
  logic [ADDR_W-1:0] acc_addr;
  logic              desel;
  logic [LANES-1:0]  wmask;
  logic [ADDR_W-1:0] raddr_q;
  logic [DATA_W-1:0] rword;
  logic [DATA_W-1:0] dout_q;
  logic              drv_q;

  sram_write_qual #(.LANES(LANES)) u_qual (
    .wr_en     (wr_en),
    .wr_all    (wr_all),
    .lane_en   (lane_en),
    .lane_mask (lane_mask),
    .wr_any    (wr_any)
  );

  sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .cpu_start  (cpu_start),
    .ctl_start  (ctl_start),
    .chip_sel   (chip_sel),
    .burst_step (burst_step),
    .interleave (interleave),
    .wr_any     (wr_any),
    .addr       (addr),
    .acc_op     (acc_op),
    .acc_addr   (acc_addr),
    .desel      (desel)
  );

  assign wmask = (acc_op == ACC_WRITE) ? lane_mask : '0;

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .we_mask (wmask),
    .waddr   (acc_addr),
    .wdata   (wdata),
    .raddr   (raddr_q),
    .rword   (rword)
  );

  sram_read_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep   (sleep),
    .rd_go   (acc_op == ACC_READ),
    .rd_addr (acc_addr),
    .desel   (desel),
    .rword   (rword),
    .raddr_q (raddr_q),
    .dout_q  (dout_q),
    .drv_q   (drv_q)
  );

  assign rdata       = dout_q;
  assign rdata_drive = drv_q & out_en & ~sleep;

endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_start,
  input logic              chip_sel,
  input logic              sleep,
  input logic              out_en,
  input logic              rdata_drive,
  input logic [DATA_W-1:0] rdata,
  input logic [LANES-1:0]  wmask,
  input logic              drv_q
);

  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_drive);

  p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(rdata));

  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !rdata_drive);

  p_cpu_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_start && !sleep) |-> (wmask == '0));

  p_read_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_start && chip_sel && !sleep, 2) && !$past(sleep)) |-> drv_q);

endmodule

bind sram_burst_pipe sram_burst_chk #(.LANES(LANES), .DATA_W(LANES*LANE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_start   (cpu_start),
  .chip_sel    (chip_sel),
  .sleep       (sleep),
  .out_en      (out_en),
  .rdata_drive (rdata_drive),
  .rdata       (rdata),
  .wmask       (wmask),
  .drv_q       (drv_q)
);

// File: tb/sram_burst_pipe_tb.sv
module sram_burst_pipe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;

  logic clk = 1'b0;
  logic rst_n;
  logic [ADDR_W-1:0] addr;
  logic cpu_start, ctl_start, chip_sel, burst_step, interleave;
  logic wr_en, wr_all, out_en, sleep;
  logic [LANES-1:0] lane_en;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic rdata_drive;

  logic [DW-1:0] model [64];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_burst_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_start(cpu_start),
    .ctl_start(ctl_start), .chip_sel(chip_sel), .burst_step(burst_step),
    .interleave(interleave), .wr_en(wr_en), .lane_en(lane_en), .wr_all(wr_all),
    .wdata(wdata), .out_en(out_en), .sleep(sleep), .rdata(rdata),
    .rdata_drive(rdata_drive)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    cpu_start = 0; ctl_start = 0; chip_sel = 1; burst_step = 0;
    wr_en = 0; wr_all = 0; lane_en = '0; wdata = '0;
  endtask

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] a, input int k, input logic il);
    int lo;
    lo = il ? (int'(a[1:0]) ^ k) : ((int'(a[1:0]) + k) % 4);
    return {a[ADDR_W-1:2], 2'(lo)};
  endfunction

  task automatic wburst(input logic [ADDR_W-1:0] a, input logic il, input logic [DW-1:0] base);
    interleave = il;
    ctl_start = 1; chip_sel = 1; wr_all = 1; addr = a; wdata = base;
    model[beat_addr(a, 0, il)] = base;
    cyc();
    ctl_start = 0; burst_step = 1;
    for (int k = 1; k < 4; k++) begin
      wdata = base + DW'(k);
      model[beat_addr(a, k, il)] = wdata;
      cyc();
    end
    idle();
    cyc();
  endtask

  task automatic rburst(input logic [ADDR_W-1:0] a, input logic il, input string tag);
    interleave = il;
    cpu_start = 1; chip_sel = 1; addr = a;
    cyc();
    cpu_start = 0; burst_step = 1;
    for (int k = 0; k < 4; k++) begin
      if (k == 3) burst_step = 0;
      cyc();
      check(tag, rdata, model[beat_addr(a, k, il)]);
    end
    idle();
  endtask

  task automatic rd1(input logic [ADDR_W-1:0] a, input string tag);
    cpu_start = 1; chip_sel = 1; addr = a;
    cyc();
    idle();
    cyc();
    check(tag, rdata, model[a]);
    check({tag, " drive"}, DW'(rdata_drive), DW'(1));
  endtask

  task automatic t_linear();
    wburst(6'h05, 1'b0, 36'h0_1234_5670);
    rburst(6'h05, 1'b0, "R3 R4 linear burst");
    rd1(6'h04, "R4 wrap to 4");
  endtask

  task automatic t_interleave();
    wburst(6'h0A, 1'b1, 36'h9_8765_4320);
    rburst(6'h0A, 1'b1, "R5 interleaved burst");
    interleave = 0;
    rd1(6'h08, "R5 beat 2 at 8");
  endtask

  task automatic t_lane();
    logic [DW-1:0] e;
    ctl_start = 1; chip_sel = 1; wr_en = 1; lane_en = 4'b0101; wdata = '1; addr = 6'h05;
    cyc();
    idle();
    e = model[5];
    e[8:0] = 9'h1FF;
    e[26:18] = 9'h1FF;
    model[5] = e;
    cyc();
    ctl_start = 1; chip_sel = 1; wr_en = 0; lane_en = 4'b1111; wdata = '0; addr = 6'h05;
    cyc();
    idle();
    rd1(6'h05, "R7 lane write and wr_en low");
  endtask

  task automatic t_global();
    ctl_start = 1; chip_sel = 1; wr_all = 1; wr_en = 0; lane_en = '0;
    wdata = 36'hA_BCDE_F012; addr = 6'd20;
    model[20] = wdata;
    cyc();
    idle();
    rd1(6'd20, "R8 global write");
  endtask

  task automatic t_priority();
    cpu_start = 1; ctl_start = 1; chip_sel = 1; wr_all = 1; wr_en = 1; lane_en = '1;
    wdata = 36'h5_5555_5555; addr = 6'd20;
    cyc();
    idle();
    cyc();
    check("R2 read despite write enables", rdata, model[20]);
    rd1(6'd20, "R2 array unchanged");
  endtask

  task automatic t_hold();
    wburst(6'd32, 1'b0, 36'h1_0000_0000);
    ctl_start = 1; chip_sel = 1; wr_all = 1; addr = 6'd32; wdata = 36'h2_0000_0001;
    cyc();
    ctl_start = 0; burst_step = 0; wdata = 36'h2_0000_0002;
    model[32] = wdata;
    cyc();
    burst_step = 1; wdata = 36'h2_0000_0003;
    model[33] = wdata;
    cyc();
    idle();
    rd1(6'd32, "R6 hold rewrote 32");
    rd1(6'd33, "R6 step wrote 33");
    rd1(6'd34, "R6 34 untouched");
  endtask

  task automatic t_deselect();
    rd1(6'h05, "R9 pre read");
    cpu_start = 1; chip_sel = 0;
    cyc();
    idle();
    check("R9 drive after deselect edge", DW'(rdata_drive), DW'(1));
    cyc();
    check("R9 drive one edge later", DW'(rdata_drive), DW'(1));
    cyc();
    check("R9 drive off two edges later", DW'(rdata_drive), DW'(0));
    burst_step = 1; wr_all = 1; wdata = 36'hF_0F0F_0F0F;
    cyc();
    idle();
    cyc();
    check("R13 no access when idle", DW'(rdata_drive), DW'(0));
    cpu_start = 1; chip_sel = 1; addr = 6'h06;
    cyc();
    idle();
    check("R1 not driven after first edge", DW'(rdata_drive), DW'(0));
    cyc();
    check("R1 data after second edge", rdata, model[6]);
    check("R1 drive after second edge", DW'(rdata_drive), DW'(1));
    rd1(6'h05, "R13 addr 5 untouched");
  endtask

  task automatic t_oe();
    rd1(6'd20, "R10 pre read");
    out_en = 0;
    #1;
    check("R10 drive off without clock", DW'(rdata_drive), DW'(0));
    check("R10 data kept", rdata, model[20]);
    out_en = 1;
    #1;
    check("R10 drive back", DW'(rdata_drive), DW'(1));
  endtask

  task automatic t_sleep();
    ctl_start = 1; chip_sel = 1; wr_all = 1; addr = 6'd40; wdata = 36'h3_3333_3333;
    model[40] = wdata;
    cyc();
    idle();
    rd1(6'd20, "R11 pre read");
    sleep = 1;
    #1;
    check("R11 drive off in sleep", DW'(rdata_drive), DW'(0));
    ctl_start = 1; wr_all = 1; addr = 6'd40; wdata = 36'h7_7777_7777;
    cyc();
    idle();
    cyc();
    check("R11 rdata kept", rdata, model[20]);
    check("R11 still quiet", DW'(rdata_drive), DW'(0));
    sleep = 0;
    rd1(6'd40, "R11 array kept");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); interleave = 0; out_en = 1; sleep = 0; addr = '0;
    repeat (3) cyc();
    check("R12 reset rdata", rdata, '0);
    check("R12 reset drive", DW'(rdata_drive), DW'(0));
    rst_n = 1;
    cyc();
    t_linear();
    t_interleave();
    t_lane();
    t_global();
    t_priority();
    t_hold();
    t_deselect();
    t_oe();
    t_sleep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule